// File: doc/BRIEF.md
# Word-and-Tail Peripheral-to-Memory DMA Channel

This block is a single DMA channel that drains a peripheral data FIFO into memory. The block length can be any number of bytes. The channel is started with the address of a descriptor chain. It then walks that chain in memory and moves data only when the peripheral raises its request line. The peripheral is acknowledged after each chunk of beats.

Software normally builds two descriptors. The first moves the whole 32-bit words of the block, which is the block length shifted right by two. The second is chained to the first and moves the last 1 to 3 bytes with byte-wide writes. A descriptor with a zero count is passed over and the channel follows its link. A null link ends the chain. The chain completes with a one-cycle done interrupt. A memory error response aborts the chain and sets an error flag instead.

Each descriptor is four consecutive words in memory, at offsets +0, +4, +8 and +12:
- the source address, which is the peripheral FIFO;
- the destination address;
- the control word;
- the next-descriptor pointer.

Top module: `dma_tail_channel`

## Requirements
- R1: After reset, and whenever the channel is idle, mem_req, per_ack and irq_done are low. The status register reads 0. Register offsets are: 0 for the chain head pointer (ignored while busy), 1 for control (bit 0 written as 1 starts the channel when idle), and 2 for status (bit 0 busy, bit 1 done, bit 2 error).
- R2: For each descriptor, the channel issues four word reads in order at pointer+0, +4, +8 and +12. A request stays asserted, with the same address and direction, until mem_ack.
- R3: Control word fields are: count in bits [15:0], chunk code in bits [17:16], and width in bit 20 (1 selects word). In a word descriptor, each beat reads the word at the source address and writes it whole with strobe 4'b1111. The write address is the destination with its low two bits forced to 00. The destination advances by 4 per beat.
- R4: A descriptor whose count is 0 moves no data and raises no per_ack. The channel follows its link directly.
- R5: When a descriptor finishes and its next pointer is 0, the channel drops busy and pulses irq_done for exactly one cycle. Status then reads 2 (done set, not busy).
- R6: In a byte descriptor, each beat takes byte lane src[1:0] of the source word. It writes that byte replicated on all four lanes, with a one-hot strobe on lane dst[1:0] at the exact destination address. The destination advances by 1 per beat.
- R7: No data beat starts while per_req is low. On each request the channel moves min(1 << chunk code, remaining count) beats, then pulses per_ack for one cycle.
- R8: A read of status returns the done and error flags and clears them, so the next read shows neither.
- R9: An error response during a descriptor fetch, source read or destination write ends the chain at once. Busy drops, status reads 4 (error), and irq_done does not pulse.
- R10: Once the chain has written any data, the destination field of each later descriptor is ignored. Writes continue from the address after the last write. A destination field is used only while nothing has yet been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status flags on a status read) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_be | output | 4 | Byte-lane strobes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Error response, valid with mem_ack |
| per_req | input | 1 | Peripheral data request |
| per_ack | output | 1 | One-cycle acknowledge after each chunk |
| irq_done | output | 1 | One-cycle chain completion pulse |

## Verification
Every memory access takes two clocks: the request appears one edge after the state change, and the bench memory answers from the falling edge. Each write is therefore compared against a queue of expected writes at the very falling edge where it is accepted, rather than at a fixed latency. per_ack is counted on the falling edge after the edge that raised it. Completion is awaited with a bounded wait for irq_done, and the pulse counts are checked a few cycles later. Status is read with the strobe set up half a cycle before the clearing edge, and the idle-without-request case is held for 40 cycles before the write count is checked.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LINK,
      ST_FETCH,
      ST_EVAL,
      ST_WAIT,
      ST_READ,
      ST_WRITE,
      ST_HANDOFF
   } dmt_state_e;

   localparam logic [1:0] OFS_HEAD = 2'd0;
   localparam logic [1:0] OFS_CTRL = 2'd1;
   localparam logic [1:0] OFS_STAT = 2'd2;

   localparam int unsigned CTL_CHUNK_LSB = 16;
   localparam int unsigned CTL_WORD_BIT  = 20;

endpackage

// File: rtl/dmt_regs.sv
module dmt_regs
   import dmt_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              busy,
   input  logic              fin_ok,
   input  logic              fin_err,
   output logic              start,
   output logic [ADDR_W-1:0] head_ptr
);

   logic done_q;
   logic err_q;

   assign start = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_ptr <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         if (reg_wr && (reg_addr == OFS_HEAD) && !busy) begin
            head_ptr <= reg_wdata[ADDR_W-1:0];
         end
         if (start || (reg_rd && (reg_addr == OFS_STAT))) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end
         if (fin_ok) begin
            done_q <= 1'b1;
         end
         if (fin_err) begin
            err_q <= 1'b1;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_HEAD: reg_rdata[ADDR_W-1:0] = head_ptr;
         OFS_CTRL: reg_rdata[0]          = busy;
         OFS_STAT: reg_rdata[2:0]        = {err_q, done_q, busy};
         default:  reg_rdata             = '0;
      endcase
   end

endmodule

// File: rtl/dmt_lanes.sv
module dmt_lanes #(
   parameter int unsigned LANES = 4,
   localparam int unsigned LW   = $clog2(LANES)
) (
   input  logic               byte_mode,
   input  logic [LW-1:0]      src_lo,
   input  logic [LW-1:0]      dst_lo,
   input  logic [8*LANES-1:0] word_in,
   output logic [8*LANES-1:0] data_out,
   output logic [LANES-1:0]   be_out
);

   logic [7:0] pick;

   always_comb begin
      pick = word_in[7:0];
      for (int k = 0; k < LANES; k++) begin
         if (src_lo == LW'(k)) begin
            pick = word_in[8*k +: 8];
         end
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign data_out[8*i +: 8] = byte_mode ? pick : word_in[8*i +: 8];
      assign be_out[i]          = !byte_mode || (dst_lo == LW'(i));
   end

endmodule

// File: rtl/dmt_engine.sv
module dmt_engine
   import dmt_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned CODE_W  = 2,
   localparam int unsigned LEFT_W = 1 << CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] head_ptr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic              per_req,
   output logic              per_ack,
   output logic              irq_done,
   output logic              busy,
   output logic              fin_ok,
   output logic              fin_err,
   output logic              byte_mode,
   output logic [1:0]        src_lo,
   output logic [1:0]        dst_lo,
   output logic [31:0]       hold
);

   dmt_state_e        st;
   logic [ADDR_W-1:0] ptr;
   logic [ADDR_W-1:0] d_src;
   logic [ADDR_W-1:0] d_dst;
   logic [ADDR_W-1:0] d_next;
   logic [CNT_W-1:0]  d_cnt;
   logic [CODE_W-1:0] d_code;
   logic              d_word;
   logic [1:0]        fidx;
   logic [LEFT_W-1:0] left;
   logic              moved;

   assign byte_mode = !d_word;
   assign src_lo    = d_src[1:0];
   assign dst_lo    = d_dst[1:0];
   assign per_ack   = (st == ST_HANDOFF);

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = '0;
      case (st)
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = ptr + ADDR_W'({fidx, 2'b00});
         end
         ST_READ: begin
            mem_req  = 1'b1;
            mem_addr = {d_src[ADDR_W-1:2], 2'b00};
         end
         ST_WRITE: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = d_word ? {d_dst[ADDR_W-1:2], 2'b00} : d_dst;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ptr      <= '0;
         d_src    <= '0;
         d_dst    <= '0;
         d_next   <= '0;
         d_cnt    <= '0;
         d_code   <= '0;
         d_word   <= 1'b0;
         fidx     <= '0;
         left     <= '0;
         moved    <= 1'b0;
         hold     <= '0;
         busy     <= 1'b0;
         irq_done <= 1'b0;
         fin_ok   <= 1'b0;
         fin_err  <= 1'b0;
      end else begin
         irq_done <= 1'b0;
         fin_ok   <= 1'b0;
         fin_err  <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  ptr   <= head_ptr;
                  busy  <= 1'b1;
                  moved <= 1'b0;
                  st    <= ST_LINK;
               end
            end
            ST_LINK: begin
               if (ptr == '0) begin
                  busy     <= 1'b0;
                  irq_done <= 1'b1;
                  fin_ok   <= 1'b1;
                  st       <= ST_IDLE;
               end else begin
                  fidx <= '0;
                  st   <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     busy    <= 1'b0;
                     fin_err <= 1'b1;
                     st      <= ST_IDLE;
                  end else begin
                     case (fidx)
                        2'd0: d_src <= mem_rdata[ADDR_W-1:0];
                        2'd1: if (!moved) d_dst <= mem_rdata[ADDR_W-1:0];
                        2'd2: begin
                           d_cnt  <= mem_rdata[CNT_W-1:0];
                           d_code <= mem_rdata[CTL_CHUNK_LSB +: CODE_W];
                           d_word <= mem_rdata[CTL_WORD_BIT];
                        end
                        default: d_next <= mem_rdata[ADDR_W-1:0];
                     endcase
                     fidx <= fidx + 2'd1;
                     if (fidx == 2'd3) begin
                        st <= ST_EVAL;
                     end
                  end
               end
            end
            ST_EVAL: begin
               if (d_cnt == '0) begin
                  ptr <= d_next;
                  st  <= ST_LINK;
               end else begin
                  st <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (per_req) begin
                  left <= LEFT_W'(1) << d_code;
                  st   <= ST_READ;
               end
            end
            ST_READ: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     busy    <= 1'b0;
                     fin_err <= 1'b1;
                     st      <= ST_IDLE;
                  end else begin
                     hold <= mem_rdata;
                     st   <= ST_WRITE;
                  end
               end
            end
            ST_WRITE: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     busy    <= 1'b0;
                     fin_err <= 1'b1;
                     st      <= ST_IDLE;
                  end else begin
                     moved <= 1'b1;
                     d_dst <= d_dst + (d_word ? ADDR_W'(4) : ADDR_W'(1));
                     d_cnt <= d_cnt - CNT_W'(1);
                     left  <= left - LEFT_W'(1);
                     if ((d_cnt == CNT_W'(1)) || (left == LEFT_W'(1))) begin
                        st <= ST_HANDOFF;
                     end else begin
                        st <= ST_READ;
                     end
                  end
               end
            end
            ST_HANDOFF: begin
               if (d_cnt == '0) begin
                  ptr <= d_next;
                  st  <= ST_LINK;
               end else begin
                  st <= ST_WAIT;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dma_tail_channel.sv
module dma_tail_channel
   import dmt_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic              per_req,
   output logic              per_ack,
   output logic              irq_done
);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
      $error("ADDR_W must lie in 8..32");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("CNT_W must lie in 1..16");
   end
   if (CODE_W < 1 || CODE_W > 3) begin : g_bad_code_w
      $error("CODE_W must lie in 1..3");
   end

   logic              eng_busy;
   logic              start;
   logic              fin_ok;
   logic              fin_err;
   logic [ADDR_W-1:0] head_ptr;
   logic              byte_mode;
   logic [1:0]        src_lo;
   logic [1:0]        dst_lo;
   logic [31:0]       hold;
   logic [3:0]        lane_be;

   dmt_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (eng_busy),
      .fin_ok    (fin_ok),
      .fin_err   (fin_err),
      .start     (start),
      .head_ptr  (head_ptr)
   );

   dmt_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .head_ptr  (head_ptr),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack),
      .mem_err   (mem_err),
      .per_req   (per_req),
      .per_ack   (per_ack),
      .irq_done  (irq_done),
      .busy      (eng_busy),
      .fin_ok    (fin_ok),
      .fin_err   (fin_err),
      .byte_mode (byte_mode),
      .src_lo    (src_lo),
      .dst_lo    (dst_lo),
      .hold      (hold)
   );

   dmt_lanes #(.LANES(4)) u_lanes (
      .byte_mode (byte_mode),
      .src_lo    (src_lo),
      .dst_lo    (dst_lo),
      .word_in   (hold),
      .data_out  (mem_wdata),
      .be_out    (lane_be)
   );

   assign mem_be = mem_we ? lane_be : 4'b1111;

endmodule

// File: rtl/dmt_chk.sv
module dmt_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       mem_req,
   input logic       mem_we,
   input logic [1:0] mem_addr_lo,
   input logic [3:0] mem_be,
   input logic       mem_ack,
   input logic       per_ack,
   input logic       irq_done
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !per_ack)); // R1

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr_lo))); // R2

   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_be == 4'b1111) |-> (mem_addr_lo == 2'b00)); // R3

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |=> !irq_done); // R5

   AST_IRQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |-> !busy); // R5

   AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_be != 4'b1111)
         |-> ($countones(mem_be) == 1 && mem_be[mem_addr_lo])); // R6

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      per_ack |=> !per_ack); // R7

endmodule

bind dma_tail_channel dmt_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (eng_busy),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_addr_lo (mem_addr[1:0]),
   .mem_be      (mem_be),
   .mem_ack     (mem_ack),
   .per_ack     (per_ack),
   .irq_done    (irq_done)
);

// File: tb/tb_dma_tail_channel.sv
module tb_dma_tail_channel;

   localparam logic [31:0] FIFO_A = 32'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0, mem_err = 1'b0;
   logic        per_req = 1'b0, per_ack, irq_done;

   always #5 clk = ~clk;

   dma_tail_channel dut (.*);

   typedef struct {
      logic [31:0] a;
      logic [31:0] d;
      logic [3:0]  be;
      string       tag;
   } wexp_t;

   wexp_t       wq[$];
   logic [31:0] rd_log[$];
   logic [31:0] mem [logic [31:0]];
   logic [31:0] fifo_val = '0;
   int n_chk = 0, n_err = 0, wr_total = 0, ack_cnt = 0, irq_cnt = 0, cyc = 0;
   bit per_on = 1'b0;

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model: answers each request at the falling edge, one cycle later
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         mem_err <= 1'b0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
         mem_err <= 1'b0;
      end else if (mem_req) begin
         mem_ack <= 1'b1;
         if (mem_addr[31:28] == 4'hE) begin
            mem_err <= 1'b1;
         end else begin
            mem_err <= 1'b0;
            if (mem_we) begin
               logic [31:0] k, w;
               wr_total++;
               if (wq.size() == 0) begin
                  chk(1'b0, "R3 unexpected write", mem_addr, 32'h0);
               end else begin
                  wexp_t e;
                  e = wq.pop_front();
                  chk(mem_addr == e.a, {e.tag, " addr"}, mem_addr, e.a);
                  chk(mem_be == e.be, {e.tag, " strobe"}, {28'h0, mem_be}, {28'h0, e.be});
                  chk(mem_wdata == e.d, {e.tag, " data"}, mem_wdata, e.d);
               end
               k = {mem_addr[31:2], 2'b00};
               w = mem.exists(k) ? mem[k] : 32'h0;
               for (int b = 0; b < 4; b++) if (mem_be[b]) w[8*b +: 8] = mem_wdata[8*b +: 8];
               mem[k] = w;
            end else begin
               rd_log.push_back(mem_addr);
               if (mem_addr == FIFO_A) begin
                  mem_rdata <= fifo_val;
                  fifo_val = fifo_val + 32'h1;
               end else begin
                  mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (per_ack) begin
         per_req <= 1'b0;
         ack_cnt++;
      end else begin
         per_req <= per_on;
      end
      if (irq_done) irq_cnt++;
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_err++;
         $display("FAIL R5 watchdog actual=%0d expected=<150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic reg_write(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic read_sts(output logic [31:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 2'd2;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   function automatic logic [31:0] ctl(int cnt, int code, bit word);
      return (32'(word) << 20) | (32'(code) << 16) | 32'(cnt);
   endfunction

   task automatic put_desc(logic [31:0] at, logic [31:0] dst, logic [31:0] c, logic [31:0] nxt);
      mem[at] = FIFO_A; mem[at+4] = dst; mem[at+8] = c; mem[at+12] = nxt;
   endtask

   task automatic plan(int words, int bytes, logic [31:0] dw, logic [31:0] db,
                       logic [31:0] seed, string btag);
      for (int i = 0; i < words; i++) begin
         wexp_t e;
         e.a = dw + 32'(4*i); e.d = seed + 32'(i); e.be = 4'hF; e.tag = "R3";
         wq.push_back(e);
      end
      for (int j = 0; j < bytes; j++) begin
         wexp_t e;
         logic [31:0] v;
         v = seed + 32'(words + j);
         e.a = db + 32'(j); e.d = {4{v[7:0]}}; e.be = 4'(1 << e.a[1:0]); e.tag = btag;
         wq.push_back(e);
      end
   endtask

   task automatic begin_run(logic [31:0] ptr, logic [31:0] seed);
      fifo_val = seed; ack_cnt = 0; irq_cnt = 0; wr_total = 0;
      rd_log.delete();
      reg_write(2'd0, ptr);
      reg_write(2'd1, 32'h1);
   endtask

   task automatic finish_ok(int exp_acks, string tag);
      logic [31:0] s;
      for (int t = 0; t < 3000 && irq_cnt == 0; t++) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(irq_cnt == 1, "R5 irq pulses", 32'(irq_cnt), 32'd1);
      chk(wq.size() == 0, {tag, " writes outstanding"}, 32'(wq.size()), 32'd0);
      chk(ack_cnt == exp_acks, "R7 per_ack count", 32'(ack_cnt), 32'(exp_acks));
      read_sts(s);
      chk(s == 32'd2, "R5 status done", s, 32'd2);
      read_sts(s);
      chk(s == 32'd0, "R8 status cleared", s, 32'd0);
   endtask

   initial begin
      logic [31:0] s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!mem_req && !per_ack && !irq_done, "R1 idle outputs",
          {29'h0, mem_req, per_ack, irq_done}, 32'h0);
      read_sts(s);
      chk(s == 32'd0, "R1 status after reset", s, 32'd0);
      per_on = 1'b1;

      // A: 12 bytes, words only, chunk 1 -> 3 acks, null link
      put_desc(32'h100, 32'h2000, ctl(3, 0, 1'b1), 32'h0);
      plan(3, 0, 32'h2000, 32'h0, 32'h1111_0000, "R6");
      begin_run(32'h100, 32'h1111_0000);
      finish_ok(3, "R3");
      chk(rd_log.size() >= 5, "R2 read count", 32'(rd_log.size()), 32'd5);
      if (rd_log.size() >= 5) begin
         for (int i = 0; i < 4; i++)
            chk(rd_log[i] == 32'h100 + 32'(4*i), "R2 fetch order", rd_log[i], 32'h100 + 32'(4*i));
         chk(rd_log[4] == FIFO_A, "R3 source is FIFO", rd_log[4], FIFO_A);
      end

      // B: 7 bytes, 1 word then 3 bytes chunk 2; byte dst field ignored (R10)
      put_desc(32'h200, 32'h3000, ctl(1, 1, 1'b1), 32'h300);
      put_desc(32'h300, 32'h9999, ctl(3, 1, 1'b0), 32'h0);
      plan(1, 3, 32'h3000, 32'h3004, 32'h2222_00A0, "R10");
      begin_run(32'h200, 32'h2222_00A0);
      finish_ok(3, "R10");

      // C: 2 bytes, zero-count word descriptor skipped, unaligned byte dst
      put_desc(32'h400, 32'h5000, ctl(0, 0, 1'b1), 32'h500);
      put_desc(32'h500, 32'h6003, ctl(2, 0, 1'b0), 32'h0);
      plan(0, 2, 32'h0, 32'h6003, 32'h0000_0051, "R6");
      begin_run(32'h400, 32'h0000_0051);
      finish_ok(2, "R4");
      chk(rd_log.size() >= 9 && rd_log[4] == 32'h500, "R4 skip to link",
          rd_log.size() >= 9 ? rd_log[4] : 32'h0, 32'h500);

      // D: 16 bytes, chunk 4 -> single request; first held off (R7)
      per_on = 1'b0;
      put_desc(32'h600, 32'h7000, ctl(4, 2, 1'b1), 32'h0);
      plan(4, 0, 32'h7000, 32'h0, 32'h3333_0000, "R6");
      begin_run(32'h600, 32'h3333_0000);
      repeat (40) @(negedge clk);
      chk(wr_total == 0, "R7 no writes without request", 32'(wr_total), 32'd0);
      read_sts(s);
      chk(s == 32'd1, "R7 busy while waiting", s, 32'd1);
      per_on = 1'b1;
      finish_ok(1, "R7");

      // E: write error aborts
      put_desc(32'h700, 32'hE000_0000, ctl(2, 0, 1'b1), 32'h0);
      begin_run(32'h700, 32'h0);
      repeat (60) @(negedge clk);
      chk(irq_cnt == 0, "R9 no irq on error", 32'(irq_cnt), 32'd0);
      read_sts(s);
      chk(s == 32'd4, "R9 status error", s, 32'd4);
      read_sts(s);
      chk(s == 32'd0, "R8 error cleared", s, 32'd0);

      // F: descriptor fetch error aborts
      begin_run(32'hE000_0100, 32'h0);
      repeat (30) @(negedge clk);
      read_sts(s);
      chk(s == 32'd4, "R9 fetch error", s, 32'd4);
      chk(irq_cnt == 0 && wr_total == 0, "R9 nothing moved",
          32'(irq_cnt + wr_total), 32'd0);
      chk(!mem_req && !per_ack, "R1 idle after abort", {30'h0, mem_req, per_ack}, 32'h0);

      summary();
      $finish;
   end

endmodule